// File: doc/BRIEF.md
# Configurable Fill-Mode Shifter

This block is a 16-bit combinational shifter. It takes a data word, a shift amount taken from a register operand, a direction bit and a two-bit fill mode, and returns the shifted word in the same cycle. The fill mode sets what enters the vacated bit positions. The choices are zeros, ones, copies of the bit at the vacated end, or the bits pushed out at the opposite end (a rotate, which loses no bits).

The shifter is a logarithmic barrel network with four stages. The stages move the word by 1, 2, 4 and 8 positions, and each stage is enabled by one bit of the amount. Only the low four bits of the amount operand are used. A zero flag reports whether the result is all zeros. The block holds no state, so it has no states or transitions, no clock and no reset.

Top module: `fill_shifter`

## Requirements
- R1: With `dir_right`=0 and `fill_mode`=2'b00, `data_out` equals `data_in` shifted left by the effective amount, and the vacated low bits are 0.
- R2: With `dir_right`=1 and `fill_mode`=2'b00, `data_out` equals `data_in` shifted right by the effective amount, and the vacated high bits are 0.
- R3: With `fill_mode`=2'b01, the vacated bits are 1 in both directions.
- R4: With `fill_mode`=2'b10 and `dir_right`=1, the vacated high bits copy `data_in[15]`, which gives an arithmetic (sign-extending) right shift.
- R5: With `fill_mode`=2'b10 and `dir_right`=0, the vacated low bits copy `data_in[0]`.
- R6: With `fill_mode`=2'b11, the word is rotated left (`dir_right`=0) or right (`dir_right`=1). Bits leaving one end enter at the other end, so the number of set bits is unchanged.
- R7: Only `shamt[3:0]` sets the effective amount, and `shamt[15:4]` has no effect on `data_out`.
- R8: When `shamt[3:0]` is 0, `data_out` equals `data_in` for every direction and fill mode.
- R9: `zero` is 1 exactly when `data_out` is all zeros.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| data_in | input | 16 | Word to be shifted |
| shamt | input | 16 | Shift amount operand; only bits 3:0 are used |
| dir_right | input | 1 | 0 = shift left, 1 = shift right |
| fill_mode | input | 2 | 00 zeros, 01 ones, 10 edge copy, 11 rotate |
| data_out | output | 16 | Shifted result |
| zero | output | 1 | 1 when data_out is all zeros |

## Verification
On every input change, the assertions check several relations:
- A zero effective amount passes the word through unchanged.
- A rotate keeps the set-bit count, and in that mode the zero flag follows the input word.
- The edge-copy mode keeps the end bit.
- The zero and ones fills put the right value at the vacated end.
- Ignoring the high amount bits holds.

The full shifted value for each direction, mode and amount, the exact sign-extension pattern, and the zero flag against a reference result can only be shown by the bench scenarios. Those scenarios compare the design against a model built from repeated single-bit moves.

// File: rtl/fill_shift_pkg.sv
package fill_shift_pkg;
    typedef enum logic [1:0] {
        FILL_ZERO = 2'b00,
        FILL_ONE  = 2'b01,
        FILL_EDGE = 2'b10,
        FILL_ROT  = 2'b11
    } fill_mode_e;
endpackage

// File: rtl/shift_stage.sv
module shift_stage
    import fill_shift_pkg::*;
#(
    parameter int WIDTH = 16,
    parameter int DIST  = 1
) (
    input  logic [WIDTH-1:0] d_in,
    input  logic             en,
    input  logic             dir_right,
    input  fill_mode_e       mode,
    output logic [WIDTH-1:0] d_out
);
    logic [DIST-1:0] fill;

    always_comb begin
        unique case (mode)
            FILL_ZERO: fill = '0;
            FILL_ONE:  fill = '1;
            FILL_EDGE: fill = dir_right ? {DIST{d_in[WIDTH-1]}} : {DIST{d_in[0]}};
            FILL_ROT:  fill = dir_right ? d_in[DIST-1:0] : d_in[WIDTH-1 -: DIST];
            default:   fill = '0;
        endcase
    end

    always_comb begin
        if (!en)
            d_out = d_in;
        else if (dir_right)
            d_out = {fill, d_in[WIDTH-1:DIST]};
        else
            d_out = {d_in[WIDTH-DIST-1:0], fill};
    end
endmodule

// File: rtl/zero_detect.sv
module zero_detect #(
    parameter int WIDTH = 16
) (
    input  logic [WIDTH-1:0] word,
    output logic             is_zero
);
    always_comb is_zero = ~|word;
endmodule

// File: rtl/fill_shifter.sv
module fill_shifter
    import fill_shift_pkg::*;
#(
    parameter int WIDTH   = 16,
    parameter int AMT_W   = 16
) (
    input  logic [WIDTH-1:0] data_in,
    input  logic [AMT_W-1:0] shamt,
    input  logic             dir_right,
    input  logic [1:0]       fill_mode,
    output logic [WIDTH-1:0] data_out,
    output logic             zero
);
    localparam int STAGES = $clog2(WIDTH);

    fill_mode_e mode;
    logic [WIDTH-1:0] lane [STAGES+1];

    always_comb mode = fill_mode_e'(fill_mode);
    always_comb lane[0] = data_in;

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        shift_stage #(
            .WIDTH (WIDTH),
            .DIST  (1 << s)
        ) u_stage (
            .d_in      (lane[s]),
            .en        (shamt[s]),
            .dir_right (dir_right),
            .mode      (mode),
            .d_out     (lane[s+1])
        );
    end

    always_comb data_out = lane[STAGES];

    zero_detect #(.WIDTH(WIDTH)) u_zero (
        .word    (data_out),
        .is_zero (zero)
    );
endmodule

// File: rtl/fill_shifter_checker.sv
module fill_shifter_checker #(
    parameter int WIDTH = 16,
    parameter int AMT_W = 16
) (
    input logic [WIDTH-1:0] data_in,
    input logic [AMT_W-1:0] shamt,
    input logic             dir_right,
    input logic [1:0]       fill_mode,
    input logic [WIDTH-1:0] data_out,
    input logic             zero
);
    localparam int STAGES = $clog2(WIDTH);

    logic amt_nz;
    always_comb amt_nz = |shamt[STAGES-1:0];

    always_comb begin
        if (!amt_nz)
            assert_passthrough_R8: assert (data_out == data_in);
        if (fill_mode == 2'b11) begin
            assert_rotate_keeps_bits_R6: assert ($countones(data_out) == $countones(data_in));
            assert_rotate_zero_flag_R9: assert (zero == (data_in == '0));
        end
        if (fill_mode == 2'b10 && dir_right)
            assert_sign_kept_R4: assert (data_out[WIDTH-1] == data_in[WIDTH-1]);
        if (fill_mode == 2'b10 && !dir_right)
            assert_low_edge_kept_R5: assert (data_out[0] == data_in[0]);
        if (fill_mode == 2'b01 && amt_nz)
            assert_ones_enter_R3: assert (dir_right ? data_out[WIDTH-1] : data_out[0]);
        if (fill_mode == 2'b00 && amt_nz && dir_right)
            assert_zero_enter_right_R2: assert (!data_out[WIDTH-1]);
        if (fill_mode == 2'b00 && amt_nz && !dir_right)
            assert_zero_enter_left_R1: assert (!data_out[0]);
        if (shamt[STAGES-1:0] == '0 && shamt[AMT_W-1:STAGES] != '0)
            assert_high_amt_ignored_R7: assert (data_out == data_in);
    end
endmodule

bind fill_shifter fill_shifter_checker #(.WIDTH(WIDTH), .AMT_W(AMT_W)) u_checker (
    .data_in   (data_in),
    .shamt     (shamt),
    .dir_right (dir_right),
    .fill_mode (fill_mode),
    .data_out  (data_out),
    .zero      (zero)
);

// File: tb/tb_fill_shifter.sv
`timescale 1ns/1ps
module tb_fill_shifter;
    logic        clk = 0;
    logic [15:0] data_in = '0;
    logic [15:0] shamt = '0;
    logic        dir_right = 0;
    logic [1:0]  fill_mode = '0;
    logic [15:0] data_out;
    logic        zero;

    int tests = 0;
    int fails = 0;

    always #5 clk = ~clk;

    fill_shifter dut (
        .data_in   (data_in),
        .shamt     (shamt),
        .dir_right (dir_right),
        .fill_mode (fill_mode),
        .data_out  (data_out),
        .zero      (zero)
    );

    function automatic logic [15:0] model(input logic [15:0] d, input logic [15:0] a,
                                          input logic r, input logic [1:0] m);
        logic [15:0] v;
        logic nb;
        v = d;
        for (int i = 0; i < int'(a[3:0]); i++) begin
            if (r) begin
                case (m)
                    2'b00: nb = 1'b0;
                    2'b01: nb = 1'b1;
                    2'b10: nb = v[15];
                    default: nb = v[0];
                endcase
                v = {nb, v[15:1]};
            end else begin
                case (m)
                    2'b00: nb = 1'b0;
                    2'b01: nb = 1'b1;
                    2'b10: nb = v[0];
                    default: nb = v[15];
                endcase
                v = {v[14:0], nb};
            end
        end
        return v;
    endfunction

    task automatic apply(input logic [15:0] d, input logic [15:0] a, input logic r,
                         input logic [1:0] m, input string tag);
        logic [15:0] exp_v;
        @(posedge clk);
        data_in = d; shamt = a; dir_right = r; fill_mode = m;
        @(negedge clk);
        exp_v = model(d, a, r, m);
        tests++;
        if (data_out !== exp_v) begin
            fails++;
            $display("FAIL %s data_out d=%h a=%h r=%0d m=%0d actual=%h expected=%h",
                     tag, d, a, r, m, data_out, exp_v);
        end
        tests++;
        if (zero !== (exp_v == 16'h0)) begin
            fails++;
            $display("FAIL R9 zero flag (%s) actual=%0d expected=%0d", tag, zero, exp_v == 16'h0);
        end
    endtask

    task automatic check_val(input logic [15:0] exp_v, input string tag);
        tests++;
        if (data_out !== exp_v) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, data_out, exp_v);
        end
    endtask

    task automatic test_initial();
        @(negedge clk);
        check_val(16'h0000, "R8 initial pass-through");
        tests++;
        if (zero !== 1'b1) begin
            fails++;
            $display("FAIL R9 initial zero actual=%0d expected=1", zero);
        end
    endtask

    task automatic test_left_zero();
        apply(16'h00F1, 16'd4, 0, 2'b00, "R1");
        check_val(16'h0F10, "R1 fixed value");
        apply(16'hFFFF, 16'd15, 0, 2'b00, "R1");
    endtask

    task automatic test_right_zero();
        apply(16'h8F00, 16'd8, 1, 2'b00, "R2");
        check_val(16'h008F, "R2 fixed value");
        apply(16'hA5A5, 16'd3, 1, 2'b00, "R2");
    endtask

    task automatic test_ones();
        apply(16'h0000, 16'd5, 0, 2'b01, "R3");
        check_val(16'h001F, "R3 left ones");
        apply(16'h0000, 16'd5, 1, 2'b01, "R3");
        check_val(16'hF800, "R3 right ones");
    endtask

    task automatic test_edge();
        apply(16'h8001, 16'd4, 1, 2'b10, "R4");
        check_val(16'hF800, "R4 sign extend");
        apply(16'h4000, 16'd6, 1, 2'b10, "R4");
        check_val(16'h0100, "R4 positive");
        apply(16'h0003, 16'd3, 0, 2'b10, "R5");
        check_val(16'h001F, "R5 low edge copy");
        apply(16'h8002, 16'd2, 0, 2'b10, "R5");
        check_val(16'h0008, "R5 low edge zero");
    endtask

    task automatic test_rotate();
        apply(16'h8001, 16'd1, 0, 2'b11, "R6");
        check_val(16'h0003, "R6 rotate left");
        apply(16'h1234, 16'd4, 1, 2'b11, "R6");
        check_val(16'h4123, "R6 rotate right");
        apply(16'hBEEF, 16'd15, 0, 2'b11, "R6");
    endtask

    task automatic test_high_bits();
        apply(16'h1234, 16'hFFF0, 0, 2'b00, "R7");
        check_val(16'h1234, "R7 high bits only");
        apply(16'h1234, 16'h5A34, 1, 2'b11, "R7");
        check_val(16'h4123, "R7 rotate with high bits");
    endtask

    task automatic test_zero_amount();
        for (int r = 0; r < 2; r++)
            for (int m = 0; m < 4; m++) begin
                apply(16'hC3A5, 16'd0, r[0], m[1:0], "R8");
                check_val(16'hC3A5, "R8 unchanged");
            end
    endtask

    task automatic test_zero_flag();
        apply(16'h0001, 16'd1, 1, 2'b00, "R9");
        apply(16'h0000, 16'd7, 0, 2'b11, "R9");
        apply(16'h0001, 16'd1, 1, 2'b11, "R9");
    endtask

    task automatic test_sweep();
        logic [15:0] pats [4];
        pats[0] = 16'h8001; pats[1] = 16'h7FFE; pats[2] = 16'hA5C3; pats[3] = 16'h0F0F;
        for (int p = 0; p < 4; p++)
            for (int r = 0; r < 2; r++)
                for (int m = 0; m < 4; m++)
                    for (int a = 0; a < 16; a++)
                        apply(pats[p], 16'(a), r[0], m[1:0], "R1 R2 R3 R4 R5 R6 sweep");
    endtask

    initial begin
        #1000000;
        fails++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        test_initial();
        test_left_zero();
        test_right_zero();
        test_ones();
        test_edge();
        test_rotate();
        test_high_bits();
        test_zero_amount();
        test_zero_flag();
        test_sweep();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule